// File: doc/BRIEF.md
# Gate-Captured Cascaded Event Counter

This block counts rising edges of a signal under test on a free-running counter. The counter is built from cascaded stages of equal width: the lowest stage steps on each detected edge, and each higher stage steps when every stage below it wraps. Before counting, the signal passes through a synchronizer and an edge detector clocked by the system clock, so the input rate must stay below half the clock rate.

A one-cycle gate pulse latches every stage of the counter in the same clock cycle. The latched value is assembled with the upper stage in the high bits. The counter is never cleared. The count for one gate period is the difference between this capture and the previous one, taken modulo the full counter width. A capture raises a ready flag, and the consumer clears it with an acknowledge pulse. Turning the per-gate count into a frequency, by dividing by the gate time, is left to the consumer.

Top module: `gate_cap_counter`

## Requirements
- R1: After synchronous reset the captured count, the per-gate delta and the ready flag are all zero, and the running counter starts from zero.
- R2: Each low-to-high transition of `sig_in` adds exactly one to the running counter. A level held high for any number of cycles counts once.
- R3: When the low stage wraps from all ones to zero, the next stage up increments in the same cycle, so the running value is one continuous binary number of 2*HALF_W bits.
- R4: A cycle with `gate_pulse` high latches all stages together. In the next cycle `cap_count` shows the running value of the gate cycle, with the high stage in bits [2*HALF_W-1:HALF_W] and the low stage in bits [HALF_W-1:0].
- R5: On each capture, `gate_delta` becomes the new capture minus the previous capture, modulo 2^(2*HALF_W). The first capture after reset is measured from zero.
- R6: A capture does not clear or disturb the running counter. Edges keep accumulating across gates.
- R7: `ready` goes high in the cycle after a gate pulse. It goes low in the cycle after an `ack` pulse that arrives without a gate pulse. When gate and ack come in the same cycle, the gate wins and `ready` stays high.
- R8: Between gate pulses, `cap_count` and `gate_delta` hold their values, including across `ack` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal under test |
| gate_pulse | input | 1 | One-cycle pulse marking the gate edge |
| ack | input | 1 | Read acknowledge that clears `ready` |
| cap_count | output | 2*HALF_W | Running count latched at the last gate |
| gate_delta | output | 2*HALF_W | Edges counted between the last two gates |
| ready | output | 1 | A new capture has not been acknowledged yet |

## Verification
The bench builds the block with HALF_W set to 4. With that width, the low stage wraps every 16 edges and the whole 8-bit counter wraps every 256 edges. A few hundred edges are then enough to cross the stage carry many times, to roll the running value past zero, and to show that the delta stays correct modulo the width when a gate period holds more edges than the counter can represent. Random edge counts per gate are mixed with directed cases: an empty gate, a long held level, gate and acknowledge in the same cycle, and an acknowledge with no gate.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    localparam int unsigned GCC_HALF_W_DEF = 16;
    localparam int unsigned GCC_STAGES_DEF = 2;
    localparam int unsigned GCC_SYNC_DEF   = 2;

    function automatic logic all_set(input logic [63:0] v, input int unsigned w);
        logic r;
        r = 1'b1;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < w) r = r & v[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/gcc_edge_detect.sv
module gcc_edge_detect #(
    parameter int unsigned SYNC_STAGES = gcc_pkg::GCC_SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)         sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= async_in;
                else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/gcc_stage.sv
module gcc_stage #(
    parameter int unsigned W = gcc_pkg::GCC_HALF_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (step) value <= value + 1'b1;
    end
endmodule

// File: rtl/gcc_capture.sv
module gcc_capture #(
    parameter int unsigned CW = 2 * gcc_pkg::GCC_HALF_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate,
    input  logic          ack,
    input  logic [CW-1:0] live,
    output logic [CW-1:0] snap,
    output logic [CW-1:0] delta,
    output logic          flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            delta <= '0;
            flag  <= 1'b0;
        end else begin
            if (gate) begin
                snap  <= live;
                delta <= live - snap;
                flag  <= 1'b1;
            end else if (ack) begin
                flag  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gate_cap_counter.sv
module gate_cap_counter #(
    parameter int unsigned HALF_W      = gcc_pkg::GCC_HALF_W_DEF,
    parameter int unsigned SYNC_STAGES = gcc_pkg::GCC_SYNC_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sig_in,
    input  logic                  gate_pulse,
    input  logic                  ack,
    output logic [2*HALF_W-1:0]   cap_count,
    output logic [2*HALF_W-1:0]   gate_delta,
    output logic                  ready
);
    localparam int unsigned NSTG = gcc_pkg::GCC_STAGES_DEF;
    localparam int unsigned CW   = NSTG * HALF_W;

    logic                  edge_rise;
    logic [NSTG-1:0]       step;
    logic [HALF_W-1:0]     stage_val [NSTG];
    logic [CW-1:0]         live_count;

    gcc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .async_in(sig_in), .rise(edge_rise)
    );

    genvar s;
    generate
        for (s = 0; s < NSTG; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign step[s] = edge_rise;
            end else begin : g_next
                assign step[s] = step[s-1] &
                    gcc_pkg::all_set(64'(stage_val[s-1]), HALF_W);
            end
            gcc_stage #(.W(HALF_W)) u_stage (
                .clk(clk), .rst(rst), .step(step[s]), .value(stage_val[s])
            );
            assign live_count[s*HALF_W +: HALF_W] = stage_val[s];
        end
    endgenerate

    gcc_capture #(.CW(CW)) u_cap (
        .clk(clk), .rst(rst), .gate(gate_pulse), .ack(ack),
        .live(live_count), .snap(cap_count), .delta(gate_delta), .flag(ready)
    );
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
    parameter int unsigned HALF_W = gcc_pkg::GCC_HALF_W_DEF
) (
    input logic                clk,
    input logic                rst,
    input logic                gate_pulse,
    input logic                ack,
    input logic                edge_rise,
    input logic [2*HALF_W-1:0] live,
    input logic [2*HALF_W-1:0] cap_count,
    input logic [2*HALF_W-1:0] gate_delta,
    input logic                ready
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        edge_rise |=> live == $past(live) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !edge_rise |=> $stable(live));

    assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_rise && live[HALF_W-1:0] == {HALF_W{1'b1}}) |=>
        live[2*HALF_W-1:HALF_W] == $past(live[2*HALF_W-1:HALF_W]) + 1'b1);

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        gate_pulse |=> cap_count == $past(live));

    assert_delta_R5: assert property (@(posedge clk) disable iff (rst)
        gate_pulse |=> gate_delta == $past(live) - $past(cap_count));

    assert_ready_set_R7: assert property (@(posedge clk) disable iff (rst)
        gate_pulse |=> ready);

    assert_ready_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !gate_pulse) |=> !ready);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_pulse |=> $stable(cap_count) && $stable(gate_delta));
endmodule

bind gate_cap_counter gcc_checker #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .gate_pulse(gate_pulse), .ack(ack),
    .edge_rise(edge_rise), .live(live_count), .cap_count(cap_count),
    .gate_delta(gate_delta), .ready(ready)
);

// File: tb/tb_gate_cap_counter.sv
module tb_gate_cap_counter;
    localparam int unsigned HW = 4;
    localparam int unsigned CW = 2 * HW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic gate_pulse = 1'b0;
    logic ack = 1'b0;
    logic [CW-1:0] cap_count, gate_delta;
    logic ready;

    int total = 0;
    int bad = 0;
    int edges = 0;
    logic [CW-1:0] exp_cap = '0;
    logic [CW-1:0] exp_delta = '0;

    always #2.5 clk = ~clk;

    gate_cap_counter #(.HALF_W(HW)) dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .gate_pulse(gate_pulse),
        .ack(ack), .cap_count(cap_count), .gate_delta(gate_delta), .ready(ready)
    );

    function automatic logic [CW-1:0] model_cap(input int n);
        return CW'(n);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sig_in = 1'b1;
            @(negedge clk);
            @(negedge clk) sig_in = 1'b0;
            @(negedge clk);
        end
        edges += n;
    endtask

    task automatic do_gate(input logic with_ack, input string req);
        logic [CW-1:0] newc;
        repeat (4) @(negedge clk);
        gate_pulse = 1'b1;
        ack = with_ack;
        @(negedge clk);
        gate_pulse = 1'b0;
        ack = 1'b0;
        newc = model_cap(edges);
        exp_delta = newc - exp_cap;
        exp_cap = newc;
        check({req, " cap"}, int'(cap_count), int'(exp_cap));
        check({req, " delta"}, int'(gate_delta), int'(exp_delta));
        check({req, " ready"}, int'(ready), 1);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog actual=timeout expected=done");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 cap", int'(cap_count), 0);
        check("R1 delta", int'(gate_delta), 0);
        check("R1 ready", int'(ready), 0);

        // R5: first capture measured from zero
        pulses(5);
        do_gate(1'b0, "R5 first");

        // R7: ack clears ready; R8: values hold across ack
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        check("R7 ack clears", int'(ready), 0);
        check("R8 cap hold", int'(cap_count), int'(exp_cap));
        check("R8 delta hold", int'(gate_delta), int'(exp_delta));

        // R2: empty gate gives zero delta
        do_gate(1'b0, "R2 empty");

        // R2: long held level counts once
        @(negedge clk) sig_in = 1'b1;
        repeat (30) @(negedge clk);
        sig_in = 1'b0;
        edges += 1;
        do_gate(1'b0, "R2 held");

        // R3: cross low-stage boundary
        pulses(17);
        do_gate(1'b0, "R3 carry");

        // R7: gate and ack together, gate wins
        pulses(3);
        do_gate(1'b1, "R7 gate+ack");

        // R6 / R5: wrap of full counter, delta modulo width
        pulses(300);
        do_gate(1'b0, "R6 wrap");

        // R4 / R5 / R6: random edge counts per gate
        for (int r = 0; r < 20; r++) begin
            pulses(int'($urandom_range(0, 40)));
            do_gate(1'($urandom_range(0, 1)), "R4 random");
        end

        // R8: no change without gate while edges arrive
        pulses(6);
        check("R8 cap idle", int'(cap_count), int'(exp_cap));
        check("R8 delta idle", int'(gate_delta), int'(exp_delta));
        do_gate(1'b0, "R6 after idle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule